// File: doc/BRIEF.md
# CDR lock source selector

This block decides, once per bit clock, whether a receive clock-recovery loop should follow its local reference clock or lock onto the incoming serial stream. It combines three pass/fail checks: an external signal-level flag, an external frequency-range flag, and an internal transition density detector that watches the sampled serial bits. A check-enable pin picks which of these checks take part. An active-low override forces the loop onto the reference clock.

Two registered outputs result. One selects the tracking source. The other is an active-low link fault indicator that is high only while the loop is tracking data with every enabled check passing. The analog loop, the level detector and the frequency comparator are outside the block and appear here only as their flags.

Top module: `cdr_lock_sel`

## Requirements
- R1: While `rst_ni` is low, and asynchronously as soon as it falls, `trk_data_o` is 0 (reference clock) and `link_fault_no` is 0 (fault). They keep these values until the first bit clock edge after reset is released.
- R2: With `chk_en_i` = 1 and `use_local_ni` = 1, `trk_data_o` becomes 1 (track data) only when `lvl_ok_i`, `rng_ok_i` and the density check all pass.
- R3: If any enabled check fails, `trk_data_o` goes to 0. It returns to 1 on the first edge at which every enabled check passes again.
- R4: With `chk_en_i` = 0, only `rng_ok_i` decides the source. A failing `lvl_ok_i` or a failing density check has no effect on either output.
- R5: The density check compares each sampled bit with the previous one, which is taken as 0 after reset. It counts successive samples that equal their predecessor, saturating at `RUN_LIMIT`, and any differing sample clears the count. The check fails while the count equals `RUN_LIMIT`.
- R6: While `use_local_ni` = 0, `trk_data_o` is 0 whatever the checks report.
- R7: While `use_local_ni` = 0, `link_fault_no` is 0.
- R8: `link_fault_no` is 1 only in a cycle in which `trk_data_o` is 1.
- R9: Both outputs are registered. A change on the flags or pins shows at the outputs after one bit clock edge. A serial bit affects them after two edges: one edge for the counter and one for the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_bit_i | input | 1 | Sampled serial data bit |
| lvl_ok_i | input | 1 | Signal level within limits |
| rng_ok_i | input | 1 | Frequency within range |
| chk_en_i | input | 1 | 1: use all three checks; 0: range check only |
| use_local_ni | input | 1 | Active low: force reference clock |
| trk_data_o | output | 1 | 1: track serial data; 0: track reference |
| link_fault_no | output | 1 | Active-low link fault indicator |

## Verification
The bench instantiates the block with `RUN_LIMIT` = 16 rather than the default 60. At that value, saturation of the run counter, the exact cycle at which the density check trips, and recovery on the next transition all occur many times within a short run. Directed phases test each check alone, the range-only mode and the override. A long random phase then mixes every input, with run lengths chosen to fall on both sides of the limit.

// File: rtl/lsel_pkg.sv
package lsel_pkg;
  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_DATA = 1'b1
  } lock_src_e;
endpackage

// File: rtl/lsel_density_det.sv
module lsel_density_det #(
  parameter int RUN_LIMIT = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic dens_ok_o
);
  localparam int CNT_W = $clog2(RUN_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LIMIT);

  logic             prev_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= bit_i;
      if (bit_i != prev_q)  run_q <= '0;
      else if (run_q != LIMIT) run_q <= run_q + 1'b1;
    end
  end

  assign dens_ok_o = (run_q != LIMIT);
endmodule

// File: rtl/lsel_decide.sv
module lsel_decide
  import lsel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_ok_i,
  input  logic rng_ok_i,
  input  logic dens_ok_i,
  input  logic chk_en_i,
  input  logic use_local_ni,
  output logic trk_data_o,
  output logic link_fault_no
);
  lock_src_e src_d, src_q;
  logic      checks_ok;
  logic      lfi_q;

  always_comb begin
    checks_ok = chk_en_i ? (lvl_ok_i & rng_ok_i & dens_ok_i) : rng_ok_i;
    src_d     = (use_local_ni && checks_ok) ? SRC_DATA : SRC_REF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_REF;
      lfi_q <= 1'b0;
    end else begin
      src_q <= src_d;
      lfi_q <= (src_d == SRC_DATA);
    end
  end

  assign trk_data_o    = (src_q == SRC_DATA);
  assign link_fault_no = lfi_q;
endmodule

// File: rtl/cdr_lock_sel.sv
module cdr_lock_sel #(
  parameter int RUN_LIMIT = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_bit_i,
  input  logic lvl_ok_i,
  input  logic rng_ok_i,
  input  logic chk_en_i,
  input  logic use_local_ni,
  output logic trk_data_o,
  output logic link_fault_no
);
  logic dens_ok_w;

  lsel_density_det #(.RUN_LIMIT(RUN_LIMIT)) i_dens (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (ser_bit_i),
    .dens_ok_o (dens_ok_w)
  );

  lsel_decide i_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lvl_ok_i      (lvl_ok_i),
    .rng_ok_i      (rng_ok_i),
    .dens_ok_i     (dens_ok_w),
    .chk_en_i      (chk_en_i),
    .use_local_ni  (use_local_ni),
    .trk_data_o    (trk_data_o),
    .link_fault_no (link_fault_no)
  );
endmodule

// File: rtl/cdr_lock_sel_chk.sv
module cdr_lock_sel_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ser_bit_i,
  input logic lvl_ok_i,
  input logic rng_ok_i,
  input logic chk_en_i,
  input logic use_local_ni,
  input logic dens_ok_w,
  input logic trk_data_o,
  input logic link_fault_no
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  // R6
  force_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_local_ni |=> !trk_data_o);

  // R7
  force_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_local_ni |=> !link_fault_no);

  // R3
  rng_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rng_ok_i |=> !trk_data_o);

  // R2
  lvl_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_en_i && !lvl_ok_i) |=> !trk_data_o);

  // R4
  rng_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_en_i && rng_ok_i && use_local_ni) |=> trk_data_o);

  // R8
  fault_vs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_fault_no |-> trk_data_o);

  // R5
  edge_restores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && ser_bit_i != $past(ser_bit_i)) |=> dens_ok_w);
endmodule

bind cdr_lock_sel cdr_lock_sel_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ser_bit_i     (ser_bit_i),
  .lvl_ok_i      (lvl_ok_i),
  .rng_ok_i      (rng_ok_i),
  .chk_en_i      (chk_en_i),
  .use_local_ni  (use_local_ni),
  .dens_ok_w     (dens_ok_w),
  .trk_data_o    (trk_data_o),
  .link_fault_no (link_fault_no)
);

// File: tb/test_cdr_lock_sel.sv
module test_cdr_lock_sel;
  localparam int LIM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0, lvl = 1'b1, rng = 1'b1, chk_en = 1'b1, use_loc_n = 1'b1;
  logic trk, fault_n;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  // behavioural reference
  int  m_run = 0;
  bit  m_prev = 0;
  bit  m_trk = 0, m_lfi = 0;

  always #5 clk = ~clk;

  cdr_lock_sel #(.RUN_LIMIT(LIM)) i_cdr_lock_sel (
    .clk_i(clk), .rst_ni(rst_n), .ser_bit_i(ser), .lvl_ok_i(lvl),
    .rng_ok_i(rng), .chk_en_i(chk_en), .use_local_ni(use_loc_n),
    .trk_data_o(trk), .link_fault_no(fault_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_prev = 0; m_trk = 0; m_lfi = 0;
    end else begin
      bit ok;
      ok = chk_en ? (lvl && rng && (m_run < LIM)) : rng;
      m_trk = use_loc_n && ok;
      m_lfi = m_trk;
      if (ser != m_prev) m_run = 0;
      else if (m_run < LIM) m_run++;
      m_prev = ser;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "trk_data_o", trk, m_trk);
    chk(cur_req, "link_fault_no", fault_n, m_lfi);
    if (fault_n === 1'b1) chk("R8", "trk while no fault", trk, 1'b1);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_bits(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ser = ~ser;
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    #23;
    chk("R1", "trk in reset", trk, 1'b0);
    chk("R1", "fault_n in reset", fault_n, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    chk("R1", "trk before first edge", trk, 1'b0);
    chk("R1", "fault_n before first edge", fault_n, 1'b0);

    cur_req = "R2";
    toggle_bits(10);
    chk("R2", "tracking with all ok", trk, 1'b1);

    // R9: one-edge latency on a flag
    cur_req = "R9";
    rng = 1'b0;
    @(negedge clk);
    chk("R9", "rng drop after one edge", trk, 1'b0);
    rng = 1'b1;
    @(negedge clk);
    chk("R3", "recover after one edge", trk, 1'b1);

    cur_req = "R3";
    lvl = 1'b0; toggle_bits(3);
    chk("R3", "lvl fail gives ref", trk, 1'b0);
    lvl = 1'b1; toggle_bits(2);
    chk("R3", "lvl back gives data", trk, 1'b1);

    // R5: hold bit constant past the limit
    cur_req = "R5";
    ser = 1'b1; @(negedge clk); // transition sample
    for (int i = 1; i <= LIM + 1; i++) begin
      @(negedge clk);
      // count reaches LIM after LIM equal samples; output follows one edge later
      chk("R5", "density during run", trk, (i <= LIM) ? 1'b1 : 1'b0);
    end
    cyc(10);
    chk("R5", "density saturated", trk, 1'b0);
    ser = 1'b0; @(negedge clk);
    chk("R9", "bit edge not yet visible", trk, 1'b0);
    @(negedge clk);
    chk("R5", "transition restores", trk, 1'b1);

    cur_req = "R4";
    chk_en = 1'b0; lvl = 1'b0;
    cyc(LIM + 10);
    chk("R4", "lvl and density ignored", trk, 1'b1);
    chk("R4", "no fault in range-only", fault_n, 1'b1);
    rng = 1'b0; cyc(2);
    chk("R4", "range still decides", trk, 1'b0);
    rng = 1'b1; lvl = 1'b1; chk_en = 1'b1; toggle_bits(3);

    cur_req = "R6";
    use_loc_n = 1'b0; toggle_bits(4);
    chk("R6", "override forces ref", trk, 1'b0);
    chk("R7", "override shows fault", fault_n, 1'b0);
    use_loc_n = 1'b1; toggle_bits(2);
    chk("R6", "override released", trk, 1'b1);

    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 99) < 8) ser = ~ser;
      else if ($urandom_range(0, 99) < 30) ser = ~ser;
      lvl       = ($urandom_range(0, 9) != 0);
      rng       = ($urandom_range(0, 9) != 0);
      chk_en    = ($urandom_range(0, 3) != 0);
      use_loc_n = ($urandom_range(0, 19) != 0);
    end

    cur_req = "R1";
    #3 rst_n = 1'b0;
    #1;
    chk("R1", "async reset trk", trk, 1'b0);
    chk("R1", "async reset fault_n", fault_n, 1'b0);
    cyc(2); rst_n = 1'b1;
    cyc(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule